// File: doc/BRIEF.md
# Pixel Scan Address Sequencer

This block works out the order in which the pixels of a small image array are read. A start strobe begins a frame. The block then sends out one row and column address per clock, and a downstream consumer accepts each address with a ready signal. Five scan modes are available:

- **Full raster:** every pixel is visited.
- **Windowed:** only the pixels inside up to four rectangular regions are visited.
- **Subsampled:** rows and columns are skipped on a regular grid.
- **Address list:** the pixels named in a sixteen-entry table are visited in table order.
- **Binned:** square groups of neighbouring pixels are visited one group at a time.

Every visit carries a command bit that asks for a read or a reset. In address-list mode each table entry supplies this bit, so a chosen set of saturated pixels can be cleared without touching the rest of the array. In binned mode two tag outputs mark the first and the last sample of each group, so a downstream accumulator can add each group into one super pixel.

Frame markers show the first and the last address of each frame. A start strobe that arrives while a frame is running has no effect. Configuration inputs must stay stable while a frame is running. The scan mode is captured when the frame starts.

Top module: `scan_sequencer`

## Requirements
- R1: After reset `validOut`, `sofOut` and `eofOut` are low, and they stay low until a start strobe is accepted.
- R2: An address is accepted in each cycle where `validOut` and `readyIn` are both high. While `readyIn` is low, the presented address, command and tags are held unchanged.
- R3: `sofOut` is high only on the first address of a frame and `eofOut` only on the last one. `validOut` is low in the cycle after the last address is accepted.
- R4: A start strobe is ignored while a frame is active. A start that would give an empty frame produces no addresses: windowed mode with no valid window, or address-list mode with a count of zero.
- R5: `modeSel` = 0 is full raster, and codes 5 to 7 behave the same way. Every pixel is visited in row-major order, from (0,0) to the last row and last column.
- R6: `modeSel` = 1 is windowed. Windows are visited in ascending index order, and each one is scanned row-major over its inclusive bounds. A window whose first row exceeds its last row, or whose first column exceeds its last column, is skipped.
- R7: `modeSel` = 2 is subsampled. The block visits rows 0, rs, 2rs, ... and, on each of those rows, columns 0, cs, 2cs, ..., staying inside the array. A skip value of 0 acts as 1, and values above 8 act as 8.
- R8: `modeSel` = 3 is address list. Entries 0 to count-1 are visited in order, and `resetCmd` equals each entry's reset bit. A count above the table depth is clamped to the depth.
- R9: `modeSel` = 4 is binned, with `binSize` 0 = 1x1, 1 = 2x2, and 2 or 3 = 4x4. Groups are visited in raster order, and the pixels inside each group are visited row-major. `binFirst` marks a group's first pixel and `binLast` its last pixel. Outside binned mode both tags are high on every address.
- R10: `resetCmd` is low in every mode other than address list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Starts a frame when the block is idle |
| modeSel | input | 3 | Scan mode code |
| winRowFirst | input | NUM_WIN x ROW_W | First row of each window |
| winRowLast | input | NUM_WIN x ROW_W | Last row of each window, inclusive |
| winColFirst | input | NUM_WIN x COL_W | First column of each window |
| winColLast | input | NUM_WIN x COL_W | Last column of each window, inclusive |
| rowSkip | input | 4 | Row stride in subsampled mode |
| colSkip | input | 4 | Column stride in subsampled mode |
| binSize | input | 2 | Group size in binned mode |
| tblRow | input | TBL_DEPTH x ROW_W | Row address of each list entry |
| tblCol | input | TBL_DEPTH x COL_W | Column address of each list entry |
| tblReset | input | TBL_DEPTH | Per-entry command: 1 = reset, 0 = read |
| tblCount | input | CNT_W | Number of list entries in use |
| readyIn | input | 1 | Downstream accepts the presented address |
| validOut | output | 1 | An address is presented |
| rowAddr | output | ROW_W | Row address |
| colAddr | output | COL_W | Column address |
| resetCmd | output | 1 | 1 = reset the pixel, 0 = read it |
| sofOut | output | 1 | First address of the frame |
| eofOut | output | 1 | Last address of the frame |
| binFirst | output | 1 | First sample of a bin group |
| binLast | output | 1 | Last sample of a bin group |

## Verification
The bench builds the block as an 8x8 array, with ROW_W and COL_W set to 3, four windows and a sixteen-entry table. With this size a full frame is 64 addresses, so every mode, including all four 4x4 groups, finishes in a few dozen cycles. The maximum skip of 8 steps past the array edge after a single row or column. Windows can sit on the last row and column, and a table count above sixteen exercises the clamp.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam logic [2:0] SCAN_FULL = 3'd0;
  localparam logic [2:0] SCAN_WIN  = 3'd1;
  localparam logic [2:0] SCAN_SUB  = 3'd2;
  localparam logic [2:0] SCAN_RAND = 3'd3;
  localparam logic [2:0] SCAN_BIN  = 3'd4;

  localparam int SKIP_W   = 4;
  localparam int MAX_SKIP = 8;

  typedef struct packed {
    logic       load;
    logic       step;
    logic [2:0] mode;
  } scanStrobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic [2:0]  modeSel,
  input  logic        readyIn,
  input  logic        frameEmpty,
  input  logic        lastVisit,
  output scanStrobe_t strb,
  output logic        validOut,
  output logic        sofOut,
  output logic        eofOut
);
  logic       running;
  logic       firstR;
  logic [2:0] modeR;
  logic       loadNow;
  logic       stepNow;

  assign loadNow   = !running && startPulse && !frameEmpty;
  assign stepNow   = running && readyIn;
  assign strb.load = loadNow;
  assign strb.step = stepNow;
  assign strb.mode = loadNow ? modeSel : modeR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      firstR  <= 1'b0;
      modeR   <= SCAN_FULL;
    end else if (loadNow) begin
      running <= 1'b1;
      firstR  <= 1'b1;
      modeR   <= modeSel;
    end else if (stepNow) begin
      firstR <= 1'b0;
      if (lastVisit) running <= 1'b0;
    end
  end

  assign validOut = running;
  assign sofOut   = running && firstR;
  assign eofOut   = running && lastVisit;

  // R3
  idle_after_eof_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut && readyIn && eofOut |=> !validOut);

  // R3
  sof_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validOut) |-> sofOut);

  // R3
  single_sof_chk: assert property (@(posedge clk) disable iff (!rstN)
    sofOut && readyIn && !eofOut |=> !sofOut);
endmodule

// File: rtl/scan_path.sv
module scan_path
  import scan_pkg::*;
#(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 4,
  parameter int NUM_WIN   = 4,
  parameter int TBL_DEPTH = 16,
  parameter int CNT_W     = 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  scanStrobe_t                       strb,
  input  logic                              active,
  input  logic [2:0]                        modeSel,
  input  logic [NUM_WIN-1:0][ROW_W-1:0]     winRowFirst,
  input  logic [NUM_WIN-1:0][ROW_W-1:0]     winRowLast,
  input  logic [NUM_WIN-1:0][COL_W-1:0]     winColFirst,
  input  logic [NUM_WIN-1:0][COL_W-1:0]     winColLast,
  input  logic [SKIP_W-1:0]                 rowSkip,
  input  logic [SKIP_W-1:0]                 colSkip,
  input  logic [1:0]                        binSize,
  input  logic [TBL_DEPTH-1:0][ROW_W-1:0]   tblRow,
  input  logic [TBL_DEPTH-1:0][COL_W-1:0]   tblCol,
  input  logic [TBL_DEPTH-1:0]              tblReset,
  input  logic [CNT_W-1:0]                  tblCount,
  output logic                              frameEmpty,
  output logic                              lastVisit,
  output logic [ROW_W-1:0]                  rowAddr,
  output logic [COL_W-1:0]                  colAddr,
  output logic                              resetCmd,
  output logic                              binFirst,
  output logic                              binLast
);
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
  localparam logic [ROW_W-1:0] MAX_ROW = '1;
  localparam logic [COL_W-1:0] MAX_COL = '1;

  function automatic int clampSkip(input logic [SKIP_W-1:0] v);
    if (v == '0) return 1;
    if (int'(v) > MAX_SKIP) return MAX_SKIP;
    return int'(v);
  endfunction

  logic [ROW_W-1:0] rowR, rowNext;
  logic [COL_W-1:0] colR, colNext;
  logic [WIN_W-1:0] winIdx, winNext, firstWin, laterWin;
  logic [IDX_W-1:0] tblIdx, tblNext;
  logic [NUM_WIN-1:0] winValid;
  logic anyWin, hasLater;
  logic isWin, isSub, isRand, isBin;
  logic [ROW_W-1:0] rowMask;
  logic [COL_W-1:0] colMask;
  int rowStep, colStep, rowSum, colSum, effCount, binSpan;

  assign isWin  = (strb.mode == SCAN_WIN);
  assign isSub  = (strb.mode == SCAN_SUB);
  assign isRand = (strb.mode == SCAN_RAND);
  assign isBin  = (strb.mode == SCAN_BIN);

  assign rowStep  = clampSkip(rowSkip);
  assign colStep  = clampSkip(colSkip);
  assign effCount = (int'(tblCount) > TBL_DEPTH) ? TBL_DEPTH : int'(tblCount);
  assign binSpan  = (binSize == 2'd0) ? 0 : (binSize == 2'd1) ? 1 : 3;
  assign rowMask  = isBin ? ROW_W'(binSpan) : '0;
  assign colMask  = isBin ? COL_W'(binSpan) : '0;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_winValid
    assign winValid[w] = (winRowFirst[w] <= winRowLast[w]) &&
                         (winColFirst[w] <= winColLast[w]);
  end

  always_comb begin
    firstWin = '0;
    anyWin   = 1'b0;
    laterWin = '0;
    hasLater = 1'b0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (winValid[w]) begin
        firstWin = WIN_W'(w);
        anyWin   = 1'b1;
        if (w > int'(winIdx)) begin
          laterWin = WIN_W'(w);
          hasLater = 1'b1;
        end
      end
    end
  end

  assign frameEmpty = ((modeSel == SCAN_WIN) && !anyWin) ||
                      ((modeSel == SCAN_RAND) && (effCount == 0));

  assign rowSum = int'(rowR) + rowStep;
  assign colSum = int'(colR) + colStep;

  always_comb begin
    rowNext   = rowR;
    colNext   = colR;
    winNext   = winIdx;
    tblNext   = tblIdx;
    lastVisit = 1'b0;
    if (isWin) begin
      if (colR != winColLast[winIdx]) begin
        colNext = colR + 1'b1;
      end else if (rowR != winRowLast[winIdx]) begin
        rowNext = rowR + 1'b1;
        colNext = winColFirst[winIdx];
      end else if (hasLater) begin
        winNext = laterWin;
        rowNext = winRowFirst[laterWin];
        colNext = winColFirst[laterWin];
      end else begin
        lastVisit = 1'b1;
      end
    end else if (isSub) begin
      if (colSum <= int'(MAX_COL)) begin
        colNext = COL_W'(colSum);
      end else if (rowSum <= int'(MAX_ROW)) begin
        rowNext = ROW_W'(rowSum);
        colNext = '0;
      end else begin
        lastVisit = 1'b1;
      end
    end else if (isRand) begin
      if (int'(tblIdx) >= effCount - 1) lastVisit = 1'b1;
      else tblNext = tblIdx + 1'b1;
    end else begin
      if (rowR == MAX_ROW && colR == MAX_COL) begin
        lastVisit = 1'b1;
      end else if ((colR & colMask) != colMask) begin
        colNext = colR + 1'b1;
      end else if ((rowR & rowMask) != rowMask) begin
        rowNext = rowR + 1'b1;
        colNext = colR & ~colMask;
      end else if (colR != MAX_COL) begin
        rowNext = rowR & ~rowMask;
        colNext = colR + 1'b1;
      end else begin
        rowNext = rowR + 1'b1;
        colNext = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowR   <= '0;
      colR   <= '0;
      winIdx <= '0;
      tblIdx <= '0;
    end else if (strb.load) begin
      rowR   <= isWin ? winRowFirst[firstWin] : '0;
      colR   <= isWin ? winColFirst[firstWin] : '0;
      winIdx <= firstWin;
      tblIdx <= '0;
    end else if (strb.step && !lastVisit) begin
      rowR   <= rowNext;
      colR   <= colNext;
      winIdx <= winNext;
      tblIdx <= tblNext;
    end
  end

  assign rowAddr  = isRand ? tblRow[tblIdx] : rowR;
  assign colAddr  = isRand ? tblCol[tblIdx] : colR;
  assign resetCmd = isRand && tblReset[tblIdx];
  assign binFirst = ((rowR & rowMask) == '0) && ((colR & colMask) == '0);
  assign binLast  = ((rowR & rowMask) == rowMask) && ((colR & colMask) == colMask);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    active && !strb.step |=> $stable(rowAddr) && $stable(colAddr) && $stable(resetCmd));

  // R6
  win_bounds_chk: assert property (@(posedge clk) disable iff (!rstN)
    active && isWin |-> rowR >= winRowFirst[winIdx] && rowR <= winRowLast[winIdx] &&
                        colR >= winColFirst[winIdx] && colR <= winColLast[winIdx]);

  // R7
  sub_grid_chk: assert property (@(posedge clk) disable iff (!rstN)
    active && isSub |-> (int'(rowR) % rowStep) == 0 && (int'(colR) % colStep) == 0);

  // R9
  bin_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    active && isBin && strb.step && binLast && !lastVisit |=> binFirst);
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
#(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 4,
  parameter int NUM_WIN   = 4,
  parameter int TBL_DEPTH = 16,
  localparam int CNT_W    = $clog2(TBL_DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            startPulse,
  input  logic [2:0]                      modeSel,
  input  logic [NUM_WIN-1:0][ROW_W-1:0]   winRowFirst,
  input  logic [NUM_WIN-1:0][ROW_W-1:0]   winRowLast,
  input  logic [NUM_WIN-1:0][COL_W-1:0]   winColFirst,
  input  logic [NUM_WIN-1:0][COL_W-1:0]   winColLast,
  input  logic [3:0]                      rowSkip,
  input  logic [3:0]                      colSkip,
  input  logic [1:0]                      binSize,
  input  logic [TBL_DEPTH-1:0][ROW_W-1:0] tblRow,
  input  logic [TBL_DEPTH-1:0][COL_W-1:0] tblCol,
  input  logic [TBL_DEPTH-1:0]            tblReset,
  input  logic [CNT_W-1:0]                tblCount,
  input  logic                            readyIn,
  output logic                            validOut,
  output logic [ROW_W-1:0]                rowAddr,
  output logic [COL_W-1:0]                colAddr,
  output logic                            resetCmd,
  output logic                            sofOut,
  output logic                            eofOut,
  output logic                            binFirst,
  output logic                            binLast
);
  scanStrobe_t strb;
  logic frameEmpty;
  logic lastVisit;

  scan_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .modeSel    (modeSel),
    .readyIn    (readyIn),
    .frameEmpty (frameEmpty),
    .lastVisit  (lastVisit),
    .strb       (strb),
    .validOut   (validOut),
    .sofOut     (sofOut),
    .eofOut     (eofOut)
  );

  scan_path #(
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .NUM_WIN   (NUM_WIN),
    .TBL_DEPTH (TBL_DEPTH),
    .CNT_W     (CNT_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .active      (validOut),
    .modeSel     (modeSel),
    .winRowFirst (winRowFirst),
    .winRowLast  (winRowLast),
    .winColFirst (winColFirst),
    .winColLast  (winColLast),
    .rowSkip     (rowSkip),
    .colSkip     (colSkip),
    .binSize     (binSize),
    .tblRow      (tblRow),
    .tblCol      (tblCol),
    .tblReset    (tblReset),
    .tblCount    (tblCount),
    .frameEmpty  (frameEmpty),
    .lastVisit   (lastVisit),
    .rowAddr     (rowAddr),
    .colAddr     (colAddr),
    .resetCmd    (resetCmd),
    .binFirst    (binFirst),
    .binLast     (binLast)
  );
endmodule

// File: tb/scan_sequencer_test.sv
`timescale 1ns/1ps
module scan_sequencer_test;
  localparam int RW = 3;
  localparam int CW = 3;
  localparam int NW = 4;
  localparam int TD = 16;
  localparam int NPIX = 64;

  // case word: {mode[2:0], rowSkip[3:0], colSkip[3:0], binSize[1:0]}
  localparam int NCASE = 11;
  localparam logic [12:0] CASES [NCASE] = '{
    {3'd0, 4'd1, 4'd1, 2'd0},
    {3'd2, 4'd2, 4'd3, 2'd0},
    {3'd2, 4'd8, 4'd1, 2'd0},
    {3'd2, 4'd1, 4'd8, 2'd0},
    {3'd2, 4'd0, 4'd9, 2'd0},
    {3'd4, 4'd1, 4'd1, 2'd1},
    {3'd4, 4'd1, 4'd1, 2'd2},
    {3'd4, 4'd1, 4'd1, 2'd0},
    {3'd1, 4'd1, 4'd1, 2'd0},
    {3'd3, 4'd1, 4'd1, 2'd0},
    {3'd6, 4'd1, 4'd1, 2'd3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [2:0] modeSel = '0;
  logic [NW-1:0][RW-1:0] winRowFirst, winRowLast;
  logic [NW-1:0][CW-1:0] winColFirst, winColLast;
  logic [3:0] rowSkip = 4'd1, colSkip = 4'd1;
  logic [1:0] binSize = '0;
  logic [TD-1:0][RW-1:0] tblRow;
  logic [TD-1:0][CW-1:0] tblCol;
  logic [TD-1:0] tblReset;
  logic [4:0] tblCount = 5'd0;
  logic readyIn = 1'b1;
  logic validOut, resetCmd, sofOut, eofOut, binFirst, binLast;
  logic [RW-1:0] rowAddr;
  logic [CW-1:0] colAddr;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int expRow[NPIX], expCol[NPIX], expRst[NPIX], expBf[NPIX], expBl[NPIX];
  int expN;

  always #2.5 clk = ~clk;

  scan_sequencer #(.ROW_W(RW), .COL_W(CW), .NUM_WIN(NW), .TBL_DEPTH(TD)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .modeSel(modeSel),
    .winRowFirst(winRowFirst), .winRowLast(winRowLast),
    .winColFirst(winColFirst), .winColLast(winColLast),
    .rowSkip(rowSkip), .colSkip(colSkip), .binSize(binSize),
    .tblRow(tblRow), .tblCol(tblCol), .tblReset(tblReset), .tblCount(tblCount),
    .readyIn(readyIn), .validOut(validOut), .rowAddr(rowAddr), .colAddr(colAddr),
    .resetCmd(resetCmd), .sofOut(sofOut), .eofOut(eofOut),
    .binFirst(binFirst), .binLast(binLast)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampS(input int v);
    return (v == 0) ? 1 : (v > 8) ? 8 : v;
  endfunction

  task automatic push(input int r, input int c, input int rst, input int bf, input int bl);
    expRow[expN] = r; expCol[expN] = c; expRst[expN] = rst;
    expBf[expN] = bf; expBl[expN] = bl; expN++;
  endtask

  task automatic buildExp(input int mode, input int rs, input int cs, input int bs);
    expN = 0;
    if (mode == 1) begin
      for (int w = 0; w < NW; w++)
        if (winRowFirst[w] <= winRowLast[w] && winColFirst[w] <= winColLast[w])
          for (int r = winRowFirst[w]; r <= winRowLast[w]; r++)
            for (int c = winColFirst[w]; c <= winColLast[w]; c++) push(r, c, 0, 1, 1);
    end else if (mode == 2) begin
      for (int r = 0; r < 8; r += clampS(rs))
        for (int c = 0; c < 8; c += clampS(cs)) push(r, c, 0, 1, 1);
    end else if (mode == 3) begin
      for (int i = 0; i < ((tblCount > TD) ? TD : int'(tblCount)); i++)
        push(tblRow[i], tblCol[i], tblReset[i], 1, 1);
    end else if (mode == 4) begin
      int b = (bs == 0) ? 1 : (bs == 1) ? 2 : 4;
      for (int br = 0; br < 8; br += b)
        for (int bc = 0; bc < 8; bc += b)
          for (int sr = 0; sr < b; sr++)
            for (int sc = 0; sc < b; sc++)
              push(br + sr, bc + sc, 0, (sr == 0 && sc == 0), (sr == b-1 && sc == b-1));
    end else begin
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++) push(r, c, 0, 1, 1);
    end
  endtask

  task automatic runFrame(input string req, input bit stall, input bit midStart);
    int k = 0;
    int cyc = 0;
    int mism = 0;
    bit sofOk = 1;
    bit eofOk = 1;
    bit done = 0;
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    while (!done && cyc < 2000) begin
      readyIn = stall ? ((cyc % 3) != 1) : 1'b1;
      startPulse = midStart && (k == 2);
      #1;
      if (!validOut) begin
        done = 1;
      end else if (readyIn) begin
        if (k < expN) begin
          if (rowAddr != expRow[k] || colAddr != expCol[k] || resetCmd != expRst[k] ||
              binFirst != expBf[k] || binLast != expBl[k]) begin
            mism++;
            $display("FAIL %s visit %0d (R2/R10): actual=%0d,%0d,%0d,%0d,%0d expected=%0d,%0d,%0d,%0d,%0d",
                     req, k, rowAddr, colAddr, resetCmd, binFirst, binLast,
                     expRow[k], expCol[k], expRst[k], expBf[k], expBl[k]);
          end
        end
        if (sofOut != (k == 0)) sofOk = 0;
        if (eofOut != (k == expN - 1)) eofOk = 0;
        k++;
        if (eofOut) done = 1;
      end
      cyc++;
      @(negedge clk);
    end
    startPulse = 1'b0;
    readyIn = 1'b1;
    check(mism == 0, req, stall ? "sequence with stalls R2" : "sequence", mism, 0);
    check(k == expN, req, "visit count", k, expN);
    check(sofOk && eofOk, "R3", "frame markers", {sofOk, eofOk}, 3);
    #1;
    check(validOut == 0, "R3", "idle after last", validOut, 0);
    repeat (3) @(negedge clk);
    #1;
    check(validOut == 0, "R4", "mid-frame start ignored", validOut, 0);
  endtask

  task automatic emptyStart(input string what);
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(validOut == 0 && sofOut == 0, "R4", what, validOut, 0);
  endtask

  function automatic string reqOf(input int mode);
    case (mode)
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    winRowFirst[0] = 3'd1; winRowLast[0] = 3'd2; winColFirst[0] = 3'd3; winColLast[0] = 3'd5;
    winRowFirst[1] = 3'd4; winRowLast[1] = 3'd3; winColFirst[1] = 3'd0; winColLast[1] = 3'd7;
    winRowFirst[2] = 3'd7; winRowLast[2] = 3'd7; winColFirst[2] = 3'd7; winColLast[2] = 3'd7;
    winRowFirst[3] = 3'd0; winRowLast[3] = 3'd1; winColFirst[3] = 3'd0; winColLast[3] = 3'd0;
    for (int i = 0; i < TD; i++) begin
      tblRow[i] = RW'((i * 3) % 8);
      tblCol[i] = CW'((i * 5 + 1) % 8);
      tblReset[i] = (i % 3 == 0);
    end
    tblCount = 5'd5;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(validOut == 0 && sofOut == 0 && eofOut == 0, "R1", "reset outputs",
          {validOut, sofOut, eofOut}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(validOut == 0, "R1", "idle without start", validOut, 0);

    for (int i = 0; i < NCASE; i++) begin
      @(negedge clk);
      modeSel = CASES[i][12:10];
      rowSkip = CASES[i][9:6];
      colSkip = CASES[i][5:2];
      binSize = CASES[i][1:0];
      buildExp(CASES[i][12:10], CASES[i][9:6], CASES[i][5:2], CASES[i][1:0]);
      runFrame(reqOf(CASES[i][12:10]), i[0], 1'b0);
    end

    // R4 start strobe during an active frame
    @(negedge clk); modeSel = 3'd0;
    buildExp(0, 1, 1, 0);
    runFrame("R4", 1'b0, 1'b1);

    // R8 count above depth clamps, reset-heavy list
    @(negedge clk); modeSel = 3'd3; tblCount = 5'd20;
    buildExp(3, 1, 1, 0);
    check(expN == TD, "R8", "model clamp", expN, TD);
    runFrame("R8", 1'b1, 1'b0);

    // R4 empty frames
    @(negedge clk); tblCount = 5'd0;
    emptyStart("empty list start");
    @(negedge clk);
    modeSel = 3'd1;
    for (int w = 0; w < NW; w++) begin
      winRowFirst[w] = 3'd5; winRowLast[w] = 3'd2;
    end
    emptyStart("no valid window start");

    // R6 window flipped in columns only is skipped
    @(negedge clk);
    winRowFirst[1] = 3'd2; winRowLast[1] = 3'd6; winColFirst[1] = 3'd1; winColLast[1] = 3'd1;
    winRowFirst[3] = 3'd0; winRowLast[3] = 3'd0; winColFirst[3] = 3'd6; winColLast[3] = 3'd2;
    buildExp(1, 1, 1, 0);
    runFrame("R6", 1'b0, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule